// File: doc/BRIEF.md
# Block Write Protection Unit

This unit guards the storage array of a serial memory against writes to a chosen upper fraction of its address space. It keeps a four-bit protection setting made of an enable bit, a two-bit block selector and a lock bit. For whatever address the bus front end presents, it raises a combinational write-allowed flag. The array controller uses that flag to decide whether to acknowledge and commit the data byte. The setting also appears as a readback byte, which the front end shifts out for reads in the register address space. Every extra byte of such a read repeats the same value.

The setting is changed by a write whose address has its top bit set. The front end pulses a strobe for each received data byte and reports the number of data bytes in the transaction. The unit holds a candidate value and applies it only when the transaction ends with exactly one data byte. The stored setting models non-volatile cells: it starts at zero and is not changed by the synchronous reset. Once the lock bit is set, the setting can never change again.

Top module: `wp_guard`

## Requirements
- R1: The readback byte `rd_byte` is 00h before any setting has been written.
- R2: `rd_byte` carries the setting in bits 3..0 (bit 3 enable, bits 2..1 block select, bit 0 lock). Bits 7..4 of `rd_byte` are always 0, and bits 7..4 of a written byte are ignored.
- R3: With the enable bit at 0, `wr_ok` is 1 for every address whose bit 15 is 0.
- R4: With enable at 1, an array address is protected (`wr_ok` = 0) when its bits 13..12 are at least 3 minus the block-select value. Select 00 protects 3000h–3FFFh, 01 protects 2000h–3FFFh, 10 protects 1000h–3FFFh, and 11 protects everything. Address bit 14 is ignored.
- R5: While the lock bit is 1, no update changes the setting, and `wr_ok` is 0 for addresses with bit 15 set. While lock is 0, `wr_ok` is 1 for those addresses.
- R6: A data byte is taken as a setting candidate only if `bus_addr[15]` is 1 when `wr_stb` pulses. Bit 14 is ignored. Writes to array addresses never change the setting.
- R7: At `stop`, the candidate is applied only if `byte_cnt` equals 1. Any other count cancels the update and keeps the old setting.
- R8: The setting, and so `rd_byte` and `wr_ok`, changes only on the clock edge where `stop` is high. It is visible from the next cycle.
- R9: `rst` clears a pending candidate but leaves the stored setting unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (pending candidate only) |
| bus_addr | input | 16 | Address of the current transaction / address under test |
| wr_stb | input | 1 | One-cycle pulse per received data byte |
| wr_data | input | 8 | Data byte accompanying `wr_stb` |
| byte_cnt | input | 7 | Number of data bytes received in the transaction |
| stop | input | 1 | One-cycle pulse at the end of the transaction |
| wr_ok | output | 1 | Write allowed for `bus_addr` (combinational) |
| rd_byte | output | 8 | Setting readback, upper nibble zero |

## Verification
A wrong stored setting shows at `rd_byte` on the first cycle after the faulty `stop`. It also shows as a wrong `wr_ok` over a whole quarter-band of the array, so sweeping the two top array-address bits under each select value catches it at once. A candidate that is lost or applied too early shows either as an unchanged readback after a valid single-byte write, or as a changed readback sampled between the strobe and the stop. A lock that fails to hold shows only when a later update is tried, so the sweep ends with updates attempted after locking.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int WP_BYTE_W  = 8;
  localparam int WP_SEL_W   = 2;
  localparam int WP_FIELD_W = WP_SEL_W + 2;

  // Field order is the readback layout: enable, select, lock
  typedef struct packed {
    logic                en;
    logic [WP_SEL_W-1:0] blk;
    logic                lock;
  } wp_bits_t;

  // Lowest top-band index that is protected for a select value
  function automatic logic [WP_SEL_W-1:0] wp_first_band(input logic [WP_SEL_W-1:0] blk);
    return ~blk;
  endfunction
endpackage

// File: rtl/wp_addr_dec.sv
module wp_addr_dec #(
  parameter int ADDR_W   = 16,
  parameter int ARRAY_AW = 14,
  parameter int SEL_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_reg,
  output logic [SEL_W-1:0]  band
);
  localparam int REG_BIT = ADDR_W - 1;
  assign is_reg = addr[REG_BIT];
  assign band   = addr[ARRAY_AW-1 -: SEL_W];
endmodule

// File: rtl/wp_range_cmp.sv
module wp_range_cmp
  import wp_pkg::*;
(
  input  wp_bits_t            cfg,
  input  logic                is_reg,
  input  logic [WP_SEL_W-1:0] band,
  output logic                allow
);
  logic in_range;
  assign in_range = (band >= wp_first_band(cfg.blk));

  always_comb begin
    if (is_reg) allow = ~cfg.lock;
    else        allow = ~(cfg.en & in_range);
  end
endmodule

// File: rtl/wp_nvreg.sv
module wp_nvreg
  import wp_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 is_reg,
  input  logic                 wr_stb,
  input  logic [WP_BYTE_W-1:0] wr_data,
  input  logic [CNT_W-1:0]     byte_cnt,
  input  logic                 stop,
  output wp_bits_t             cfg
);
  localparam logic [CNT_W-1:0] ONE_BYTE = CNT_W'(1);

  wp_bits_t nv_q = '0;
  wp_bits_t cand_q;
  logic     cand_vld;
  logic     commit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_vld <= 1'b0;
      cand_q   <= '0;
    end else if (stop) begin
      cand_vld <= 1'b0;
    end else if (wr_stb && is_reg) begin
      cand_vld <= 1'b1;
      cand_q   <= wp_bits_t'(wr_data[WP_FIELD_W-1:0]);
    end
  end

  assign commit = !rst && stop && cand_vld && (byte_cnt == ONE_BYTE) && !nv_q.lock;

  always_ff @(posedge clk) begin
    if (commit) nv_q <= cand_q;
  end

  assign cfg = nv_q;
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int ARRAY_AW = 14,
  parameter int CNT_W    = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 wr_stb,
  input  logic [WP_BYTE_W-1:0] wr_data,
  input  logic [CNT_W-1:0]     byte_cnt,
  input  logic                 stop,
  output logic                 wr_ok,
  output logic [WP_BYTE_W-1:0] rd_byte
);
  localparam int PAD_W = WP_BYTE_W - WP_FIELD_W;

  logic                is_reg;
  logic [WP_SEL_W-1:0] band;
  wp_bits_t            cfg;

  wp_addr_dec #(.ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW), .SEL_W(WP_SEL_W)) u_dec (
    .addr(bus_addr), .is_reg(is_reg), .band(band)
  );

  wp_nvreg #(.CNT_W(CNT_W)) u_reg (
    .clk(clk), .rst(rst), .is_reg(is_reg), .wr_stb(wr_stb), .wr_data(wr_data),
    .byte_cnt(byte_cnt), .stop(stop), .cfg(cfg)
  );

  wp_range_cmp u_cmp (
    .cfg(cfg), .is_reg(is_reg), .band(band), .allow(wr_ok)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_byte = {{PAD_W{1'b0}}, cfg};
    end else begin : g_nopad
      assign rd_byte = cfg;
    end
  endgenerate
endmodule

module wp_guard_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CNT_W-1:0]  byte_cnt,
  input logic              stop,
  input logic              wr_ok,
  input logic [7:0]        rd_byte
);
  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_byte[7:4] == 4'h0);
  // R3
  open_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_byte[3] && !bus_addr[ADDR_W-1]) |-> wr_ok);
  // R4
  top_band_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_byte[3] && !bus_addr[ADDR_W-1] && bus_addr[13:12] == 2'b11) |-> !wr_ok);
  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_byte[0]) |-> (rd_byte == $past(rd_byte)));
  // R7
  count_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(stop) && $past(byte_cnt) != CNT_W'(1)) |-> $stable(rd_byte));
  // R8
  stop_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(stop) |-> $stable(rd_byte));
endmodule

bind wp_guard wp_guard_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .byte_cnt(byte_cnt),
  .stop(stop), .wr_ok(wr_ok), .rd_byte(rd_byte)
);

// File: tb/wp_guard_test.sv
module wp_guard_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        wr_stb = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [6:0]  byte_cnt = '0;
  logic        stop = 1'b0;
  logic        wr_ok;
  logic [7:0]  rd_byte;
  int          n_vec = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  wp_guard uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .wr_stb(wr_stb), .wr_data(wr_data),
    .byte_cnt(byte_cnt), .stop(stop), .wr_ok(wr_ok), .rd_byte(rd_byte)
  );

  function automatic logic exp_ok(input logic [3:0] s, input logic [15:0] a);
    if (a[15]) return !s[0];
    if (!s[3]) return 1'b1;
    return (int'(a[13:12]) < 3 - int'(s[2:1]));
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [7:0] d, input logic [6:0] cnt);
    @(negedge clk);
    bus_addr = a; wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; byte_cnt = cnt; stop = 1'b1;
    @(negedge clk);
    stop = 1'b0; byte_cnt = '0;
  endtask

  task automatic sweep(input logic [3:0] s, input string req);
    for (int t = 0; t < 4; t++) begin
      for (int b = 0; b < 2; b++) begin
        for (int l = 0; l < 2; l++) begin
          bus_addr = {1'b0, b[0], t[1:0], (l == 0) ? 12'h000 : 12'hFFF};
          #1;
          chk(req, {7'b0, wr_ok}, {7'b0, exp_ok(s, bus_addr)});
        end
      end
    end
    bus_addr = 16'hC123; #1;
    chk("R5", {7'b0, wr_ok}, {7'b0, exp_ok(s, bus_addr)});
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", rd_byte, 8'h00);
    sweep(4'h0, "R3");
    for (int c = 0; c < 8; c++) begin
      logic [3:0] s;
      s = {c[2:0], 1'b0};
      wr_reg(16'h8000 | 16'(c * 16'h0111), {4'hF, s}, 7'd1);
      chk("R2", rd_byte, {4'h0, s});
      sweep(s, s[3] ? "R4" : "R3");
    end
    // bit 14 ignored, high nibble ignored
    wr_reg(16'hC000, 8'hA8, 7'd1);
    chk("R6", rd_byte, 8'h08);
    // array-address write leaves setting alone
    wr_reg(16'h3FFF, 8'h06, 7'd1);
    chk("R6", rd_byte, 8'h08);
    // byte counts other than one cancel
    wr_reg(16'h8000, 8'h04, 7'd2);
    chk("R7", rd_byte, 8'h08);
    wr_reg(16'h8000, 8'h04, 7'd0);
    chk("R7", rd_byte, 8'h08);
    wr_reg(16'h8000, 8'h04, 7'd64);
    chk("R7", rd_byte, 8'h08);
    // no change between strobe and stop
    @(negedge clk);
    bus_addr = 16'h8000; wr_data = 8'h0C; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", rd_byte, 8'h08);
    byte_cnt = 7'd1; stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8", rd_byte, 8'h0C);
    // reset keeps setting, drops candidate
    @(negedge clk);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R9", rd_byte, 8'h0C);
    @(negedge clk);
    bus_addr = 16'h8000; wr_data = 8'h02; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; byte_cnt = 7'd1; stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R9", rd_byte, 8'h0C);
    // lock: enable, select 01, lock
    wr_reg(16'h8000, 8'h0B, 7'd1);
    chk("R5", rd_byte, 8'h0B);
    sweep(4'hB, "R4");
    wr_reg(16'h8000, 8'h00, 7'd1);
    chk("R5", rd_byte, 8'h0B);
    wr_reg(16'hFFFF, 8'h06, 7'd1);
    chk("R5", rd_byte, 8'h0B);
    sweep(4'hB, "R5");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule